// File: doc/BRIEF.md
# Protected Block Fetch Sequencer

This block sits on the instruction path between the decryption unit and the decode stage. Code is organised as aligned groups of eight 32-bit words. Two kinds of group exist. A single-entry group starts with two authentication-tag words and then carries six instructions. A dual-entry group starts with two copies of the first tag word and the second tag word, and then carries five instructions. For every decrypted word the sequencer works out which kind of group it belongs to and where in the group it sits. It tells the tag verifier whether the word is a tag word or an instruction. Tag words go on to decode as a no-operation word.

The group kind is taken from the word offset at which control arrives. A taken arrival at offset 1 or 2 selects a dual-entry group. The sequencer drops that word and rewinds fetch by one word to the tag copy that belongs to that path. The path entered at offset 1 must then skip the other tag copy, so a second fetch redirect jumps straight to offset 2. Control must step one word at a time through a group and may leave only after its last word. Each of the following raises a one-cycle fault that asks for a processor reset: leaving a group early, arriving at a group at an illegal offset, or placing a store in either of the first two instruction slots of a single-entry group. After a fault the sequencer returns to its idle state.

Top module: `pbs_seq`

## Requirements
- R1: While reset is held and on the first sample after it is released, out_valid, out_is_mac, out_mux, redir_valid and fault are all 0.
- R2: A word arriving at offset 0 (pc bits [4:2] equal 0) outside a group starts a single-entry group, whether the arrival is taken or sequential. Offsets 0 and 1 are tag words and offsets 2 to 7 are instructions. out_index equals the offset and out_mux is 0.
- R3: A tag word is forwarded with out_word = 32'h0100_0000 and out_is_mac = 1. An instruction word is forwarded unchanged with out_is_mac = 0.
- R4: A taken arrival at offset 1 outside a group is not forwarded. It raises a redirect to offset 0 of the same group. When the offset-0 word arrives, it is forwarded as a tag word with index 0 and a redirect to offset 2 is raised in the same cycle.
- R5: A taken arrival at offset 2 outside a group is not forwarded and raises a redirect to offset 1. From there the group proceeds one word at a time.
- R6: In a dual-entry group, offsets 0 to 2 are tag words, offsets 3 to 7 are instructions, and out_mux is 1.
- R7: While a redirect target is awaited, a word at any other address is dropped without a fault.
- R8: Outside a group, the following raise fault: a taken arrival at offsets 3 to 7, or a sequential arrival at offset 1 or 2. In the fault cycle out_valid and redir_valid are 0.
- R9: Inside a group, the following raise fault: a word whose address is not the next expected word, or a word arriving taken.
- R10: A store flag on offset 2 or 3 of a single-entry group raises fault. A store on offsets 4 to 7 of that group, or on any instruction of a dual-entry group, is accepted.
- R11: After the word at offset 7, the group is closed. The next word is treated as a new entry, so a sequential fall-through into offset 0 of the next group is accepted.
- R12: Every output reflects the input word of the previous clock cycle. After a fault, the next word is treated as an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decrypted word is present |
| in_pc | input | 32 | Byte address of the word |
| in_word | input | 32 | Decrypted word |
| in_taken | input | 1 | Word was reached by a taken branch or call |
| in_store | input | 1 | Word decodes as a store |
| out_valid | output | 1 | Word forwarded to decode and verifier |
| out_word | output | 32 | Word to decode (no-operation for tag words) |
| out_is_mac | output | 1 | Forwarded word is a tag word |
| out_index | output | 3 | Word offset inside its group |
| out_mux | output | 1 | Group is dual-entry |
| redir_valid | output | 1 | Fetch must continue at redir_pc |
| redir_pc | output | 32 | Redirect byte address |
| fault | output | 1 | Reset request |

## Verification
Every output, including the redirect and the fault, is registered once. The result for a word therefore appears exactly one rising edge after that word is presented. The bench applies each word on a falling edge and compares all outputs on the following falling edge, the first point at which that word's result is visible and before the next word can change anything. Because a redirect is due in that same slot, the bench hands the redirect target to the block as the very next word. It also inserts a stale word in between once, to exercise R7.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_EMIT,
    ACT_DROP,
    ACT_REWIND,
    ACT_FAULT
  } pbs_act_e;

  // Tag words occupy the low offsets of a group; the count depends on the kind.
  function automatic logic slot_is_mac(input logic mux, input int unsigned off,
                                       input int unsigned mac_exec, input int unsigned mac_mux);
    return off < (mux ? mac_mux : mac_exec);
  endfunction

  // Stores are barred from the first instruction slots of a single-entry group.
  function automatic logic slot_bars_store(input logic mux, input int unsigned off,
                                           input int unsigned mac_exec, input int unsigned guard);
    return !mux && (off >= mac_exec) && (off < mac_exec + guard);
  endfunction

endpackage

// File: rtl/pbs_entry.sv
module pbs_entry #(
  parameter int OFF_W       = 3,
  parameter int MUX_ENTRIES = 2
) (
  input  logic [OFF_W-1:0] off,
  input  logic             taken,
  output logic             ent_mux,
  output logic [OFF_W-1:0] rewind_off
);
  localparam logic [OFF_W-1:0] MUX_LAST = OFF_W'(MUX_ENTRIES);

  assign ent_mux    = taken && (off != '0) && (off <= MUX_LAST);
  assign rewind_off = off - OFF_W'(1);
endmodule

// File: rtl/pbs_slot.sv
module pbs_slot #(
  parameter int OFF_W     = 3,
  parameter int BLK_WORDS = 8,
  parameter int MAC_EXEC  = 2,
  parameter int MAC_MUX   = 3,
  parameter int NO_STORE  = 2
) (
  input  logic             mux,
  input  logic [OFF_W-1:0] off,
  input  logic             store,
  output logic             is_mac,
  output logic             store_bad,
  output logic             is_last,
  output logic             path_skip
);
  import pbs_pkg::*;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_WORDS - 1);

  assign is_mac    = slot_is_mac(mux, int'(unsigned'(off)), MAC_EXEC, MAC_MUX);
  assign store_bad = store && slot_bars_store(mux, int'(unsigned'(off)), MAC_EXEC, NO_STORE);
  assign is_last   = (off == LAST_OFF);
  assign path_skip = mux && (off == '0);
endmodule

// File: rtl/pbs_seq.sv
module pbs_seq #(
  parameter int          XLEN      = 32,
  parameter int          BLK_WORDS = 8,
  parameter int          MAC_EXEC  = 2,
  parameter int          MAC_MUX   = 3,
  parameter int          NO_STORE  = 2,
  parameter logic [31:0] NOP_WORD  = 32'h0100_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [XLEN-1:0]               in_pc,
  input  logic [31:0]                   in_word,
  input  logic                          in_taken,
  input  logic                          in_store,
  output logic                          out_valid,
  output logic [31:0]                   out_word,
  output logic                          out_is_mac,
  output logic [$clog2(BLK_WORDS)-1:0]  out_index,
  output logic                          out_mux,
  output logic                          redir_valid,
  output logic [XLEN-1:0]               redir_pc,
  output logic                          fault
);
  import pbs_pkg::*;

  localparam int OFF_W  = $clog2(BLK_WORDS);
  localparam int LSB    = 2;
  localparam int OFF_HI = LSB + OFF_W - 1;
  localparam int BASE_W = XLEN - OFF_HI - 1;
  localparam logic [OFF_W-1:0] SKIP_OFF = OFF_W'(MAC_MUX - 1);

  // group tracking state
  logic              st_act, st_mux, st_flush;
  logic [BASE_W-1:0] st_base;
  logic [OFF_W-1:0]  st_exp;

  logic [OFF_W-1:0]  in_off;
  logic [BASE_W-1:0] in_base;
  logic [XLEN-1:0]   exp_pc;
  logic              match;

  assign in_off  = in_pc[OFF_HI:LSB];
  assign in_base = in_pc[XLEN-1:OFF_HI+1];
  assign exp_pc  = {st_base, st_exp, 2'b00};
  assign match   = st_act && (in_pc == exp_pc);

  // slot classification: current group slot when inside, arrival offset otherwise
  logic             sel_mux;
  logic [OFF_W-1:0] sel_off;
  logic             is_mac, store_bad, is_last, path_skip;
  logic             ent_mux;
  logic [OFF_W-1:0] rewind_off;

  assign sel_mux = st_act && st_mux;
  assign sel_off = st_act ? st_exp : in_off;

  pbs_slot #(
    .OFF_W(OFF_W), .BLK_WORDS(BLK_WORDS), .MAC_EXEC(MAC_EXEC),
    .MAC_MUX(MAC_MUX), .NO_STORE(NO_STORE)
  ) slot_i (
    .mux(sel_mux), .off(sel_off), .store(in_store),
    .is_mac(is_mac), .store_bad(store_bad), .is_last(is_last), .path_skip(path_skip)
  );

  pbs_entry #(.OFF_W(OFF_W), .MUX_ENTRIES(MAC_MUX - 1)) entry_i (
    .off(in_off), .taken(in_taken), .ent_mux(ent_mux), .rewind_off(rewind_off)
  );

  // per-word decision
  pbs_act_e        act;
  logic            redir_nxt;
  logic [XLEN-1:0] redir_pc_nxt;

  always_comb begin
    act = ACT_NONE;
    if (in_valid) begin
      if (st_act) begin
        if (match && !in_taken) act = store_bad ? ACT_FAULT : ACT_EMIT;
        else if (st_flush)      act = ACT_DROP;
        else                    act = ACT_FAULT;
      end else begin
        if (in_off == '0)       act = ACT_EMIT;
        else if (ent_mux)       act = ACT_REWIND;
        else                    act = ACT_FAULT;
      end
    end
  end

  always_comb begin
    redir_nxt    = 1'b0;
    redir_pc_nxt = '0;
    if (act == ACT_REWIND) begin
      redir_nxt    = 1'b1;
      redir_pc_nxt = {in_base, rewind_off, 2'b00};
    end else if (act == ACT_EMIT && path_skip) begin
      redir_nxt    = 1'b1;
      redir_pc_nxt = {st_base, SKIP_OFF, 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_act   <= 1'b0;
      st_mux   <= 1'b0;
      st_flush <= 1'b0;
      st_base  <= '0;
      st_exp   <= '0;
    end else begin
      case (act)
        ACT_FAULT: begin
          st_act   <= 1'b0;
          st_flush <= 1'b0;
        end
        ACT_REWIND: begin
          st_act   <= 1'b1;
          st_mux   <= 1'b1;
          st_base  <= in_base;
          st_exp   <= rewind_off;
          st_flush <= 1'b1;
        end
        ACT_EMIT: begin
          if (!st_act) begin
            st_act   <= 1'b1;
            st_mux   <= 1'b0;
            st_base  <= in_base;
            st_exp   <= OFF_W'(1);
            st_flush <= 1'b0;
          end else if (path_skip) begin
            st_exp   <= SKIP_OFF;
            st_flush <= 1'b1;
          end else if (is_last) begin
            st_act   <= 1'b0;
            st_flush <= 1'b0;
          end else begin
            st_exp   <= st_exp + OFF_W'(1);
            st_flush <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_is_mac  <= 1'b0;
      out_index   <= '0;
      out_mux     <= 1'b0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      fault       <= 1'b0;
    end else begin
      out_valid   <= (act == ACT_EMIT);
      out_word    <= is_mac ? NOP_WORD : in_word;
      out_is_mac  <= (act == ACT_EMIT) && is_mac;
      out_index   <= sel_off;
      out_mux     <= (act == ACT_EMIT) && sel_mux;
      redir_valid <= redir_nxt;
      redir_pc    <= redir_pc_nxt;
      fault       <= (act == ACT_FAULT);
    end
  end

  // assertions next to the logic they guard
  assert_mac_is_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_mac |-> out_word == NOP_WORD);

  assert_mux_tag_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mux && out_index <= SKIP_OFF |-> out_is_mac);

  assert_redir_to_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> redir_pc[OFF_HI:LSB] <= SKIP_OFF);

  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !out_valid && !redir_valid);

  assert_store_slot_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && match && !in_taken && store_bad |=> fault);

  assert_stale_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && st_flush && !match |=> !fault && !out_valid);
endmodule

// File: tb/pbs_seq_tb.sv
module pbs_seq_tb_top;
  localparam logic [31:0] NOP = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_pc = '0;
  logic [31:0] in_word = '0;
  logic        in_taken = 1'b0;
  logic        in_store = 1'b0;
  logic        out_valid, out_is_mac, out_mux, redir_valid, fault;
  logic [31:0] out_word, redir_pc;
  logic [2:0]  out_index;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pbs_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_word(in_word),
    .in_taken(in_taken), .in_store(in_store), .out_valid(out_valid), .out_word(out_word),
    .out_is_mac(out_is_mac), .out_index(out_index), .out_mux(out_mux),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .fault(fault)
  );

  function automatic logic [31:0] wf(input logic [31:0] pc);
    return {8'hC3, pc[23:0]};
  endfunction

  // present one word on a falling edge, then sample on the next falling edge
  task automatic put(input logic [31:0] pc, input bit tk, input bit st);
    in_valid = 1'b1; in_pc = pc; in_word = wf(pc); in_taken = tk; in_store = st;
    @(negedge clk);
    in_valid = 1'b0; in_taken = 1'b0; in_store = 1'b0;
  endtask

  task automatic expect_out(input string req, input bit v, input logic [31:0] w, input bit mac,
                            input int idx, input bit mux, input bit rv, input logic [31:0] rpc,
                            input bit f);
    bit bad;
    checks++;
    bad = (out_valid !== v) || (redir_valid !== rv) || (fault !== f);
    if (v)  bad = bad || (out_word !== w) || (out_is_mac !== mac) ||
                  (int'(out_index) != idx) || (out_mux !== mux);
    if (rv) bad = bad || (redir_pc !== rpc);
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%0b w=%h mac=%0b idx=%0d mux=%0b rv=%0b rpc=%h f=%0b exp v=%0b w=%h mac=%0b idx=%0d mux=%0b rv=%0b rpc=%h f=%0b",
               req, out_valid, out_word, out_is_mac, out_index, out_mux, redir_valid, redir_pc,
               fault, v, w, mac, idx, mux, rv, rpc, f);
    end
  endtask

  // expected word for a given slot, computed from the role rule
  task automatic expect_slot(input string req, input logic [31:0] pc, input bit mux);
    int  off;
    bit  mac;
    off = int'(pc[4:2]);
    mac = off < (mux ? 3 : 2);
    expect_out(req, 1, mac ? NOP : wf(pc), mac, off, mux, 0, 0, 0);
  endtask

  task automatic exec_block(input logic [31:0] base, input bit tk);
    for (int i = 0; i < 8; i++) begin
      put(base + 32'(4*i), (i == 0) ? tk : 1'b0, 1'b0);
      expect_slot("R2/R3 single-entry slot", base + 32'(4*i), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] b;
    repeat (3) @(negedge clk);
    expect_out("R1 reset held", 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 after release", 0, 0, 0, 0, 0, 0, 0, 0);
    if (out_is_mac !== 0 || out_mux !== 0) begin
      checks++; fails++; $display("FAIL R1: flags got %0b%0b expected 00", out_is_mac, out_mux);
    end

    // R2 R3 R11: taken entry, fall-through into next group, another taken entry
    exec_block(32'h0000_1000, 1);
    exec_block(32'h0000_1020, 0);
    exec_block(32'h0004_2A40, 1);

    // R12: idle cycle mid-group forwards nothing and group continues
    b = 32'h0000_3000;
    put(b, 1, 0);      expect_slot("R12 entry", b, 0);
    put(b + 4, 0, 0);  expect_slot("R12 slot1", b + 4, 0);
    @(negedge clk);    expect_out("R12 idle gap", 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 2; i < 8; i++) begin
      put(b + 32'(4*i), 0, 0); expect_slot("R12 resume", b + 32'(4*i), 0);
    end

    // R4 R6 R7: dual-entry path via offset 1 with a stale word before the skip target
    b = 32'h0000_5100;
    put(b + 4, 1, 0);  expect_out("R4 entry rewind", 0, 0, 0, 0, 0, 1, b, 0);
    put(b, 0, 0);      expect_out("R4 first tag + skip", 1, NOP, 1, 0, 1, 1, b + 8, 0);
    put(b + 4, 0, 0);  expect_out("R7 stale dropped", 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 2; i < 8; i++) begin
      put(b + 32'(4*i), 0, (i == 3)); expect_slot("R6/R10 path A slot", b + 32'(4*i), 1);
    end

    // R5 R6: dual-entry path via offset 2
    b = 32'h0000_6200;
    put(b + 8, 1, 0);  expect_out("R5 entry rewind", 0, 0, 0, 0, 0, 1, b + 4, 0);
    for (int i = 1; i < 8; i++) begin
      put(b + 32'(4*i), 0, 0); expect_slot("R5/R6 path B slot", b + 32'(4*i), 1);
    end

    // R8: illegal taken entry offsets, and sequential arrival at 1 or 2
    for (int o = 3; o < 8; o++) begin
      put(32'h0000_7000 + 32'(4*o), 1, 0);
      expect_out("R8 illegal entry offset", 0, 0, 0, 0, 0, 0, 0, 1);
    end
    for (int o = 1; o < 3; o++) begin
      put(32'h0000_7400 + 32'(4*o), 0, 0);
      expect_out("R8 untaken mid entry", 0, 0, 0, 0, 0, 0, 0, 1);
    end

    // R10: store sweep over single-entry instruction slots
    for (int s = 2; s < 8; s++) begin
      b = 32'h0000_8000 + 32'(s * 32'h40);
      for (int i = 0; i < 8; i++) begin
        put(b + 32'(4*i), (i == 0), (i == s));
        if (i == s && s < 4) begin
          expect_out("R10 barred store", 0, 0, 0, 0, 0, 0, 0, 1);
          break;
        end
        expect_slot("R10 allowed slot", b + 32'(4*i), 0);
      end
    end

    // R12: after a fault the next word is an entry
    exec_block(32'h0000_9000, 1);

    // R9: early branch out, and a skipped word
    b = 32'h0000_A000;
    for (int i = 0; i < 5; i++) begin
      put(b + 32'(4*i), (i == 0), 0); expect_slot("R9 setup", b + 32'(4*i), 0);
    end
    put(32'h0000_B000, 1, 0); expect_out("R9 early exit", 0, 0, 0, 0, 0, 0, 0, 1);
    put(b, 1, 0);             expect_slot("R9 re-entry", b, 0);
    put(b + 8, 0, 0);         expect_out("R9 skipped word", 0, 0, 0, 0, 0, 0, 0, 1);
    put(b, 1, 0);             expect_slot("R9 re-entry 2", b, 0);
    put(b + 4, 1, 0);         expect_out("R9 taken in group", 0, 0, 0, 0, 0, 0, 0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule